// File: doc/BRIEF.md
# Interrupt priority level controller

This block sits next to the CPU and decides which peripheral interrupt request, if any, may break into the running program. Each of twelve request lines has a 2-bit level field. Software programs these fields through a byte-wide write port. A smaller encoded value means a more urgent source. The value 3 marks a source that is switched off.

On every cycle the block compares the levels of the pending requests against the CPU's current interrupt level, which comes from its condition code register. It raises an accept flag when a request beats that level, and reports the winner's index and level. Everything else in the interrupt sequence belongs to the CPU and to the peripherals: vector fetch, stacking, level update and request clearing.

Top module: `irq_level_ctrl`

## Requirements
- R1: After synchronous active-high reset every level field holds 3. With every request raised and the CPU level at 3, nothing is accepted.
- R2: The level fields live in three byte registers at addresses 0x7C, 0x7D and 0x7E. Source n is in register n/4, at bits [2(n%4)+1 : 2(n%4)].
- R3: A write changes the level fields on the clock edge at which the write is sampled. Before that edge, the old levels decide acceptance.
- R4: A read of any of the three register addresses returns 0xFF on `bus_rdata`, not the stored levels. For any other address, `bus_rdata` is 0x00.
- R5: A source whose field is 3 is never accepted, whatever the CPU level.
- R6: A request is accepted only when its level is numerically below `cpu_level`. A request at a level equal to or above it stays pending, and `irq_take` stays 0.
- R7: Among the eligible requests, the one with the numerically smallest level wins, whatever its index.
- R8: When the eligible requests with the smallest level are tied, the lowest source index wins.
- R9: Writes to addresses outside 0x7C..0x7E change no level field.
- R10: While `irq_take` is 0, `irq_idx` reads 0 and `irq_lvl` reads 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address for a read or a write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: 0xFF at a register address, 0x00 elsewhere |
| irq_req | input | 12 | Pending request per source, bit n is source n |
| cpu_level | input | 2 | Current CPU interrupt level |
| irq_take | output | 1 | A request is accepted |
| irq_idx | output | 4 | Index of the accepted source |
| irq_lvl | output | 2 | Level of the accepted source |

## Verification
Single requests are presented against programmed levels 0 to 3. This shows whether each field lands at its own bit position and whether level 3 is blocked. The CPU level is then swept across the same requests, which separates strict "below" from "equal". Mixed request sets cover two cases: a low-priority low-index source competing with a high-priority high-index one, and two sources sharing a level. These expose an arbiter that orders by index instead of level, or breaks ties the wrong way. Writes to neighbouring addresses, reads of the register addresses, and sampling on both sides of the write edge cover the register port.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;
    localparam int LVL_W          = 2;
    localparam int FIELDS_PER_REG = 8 / LVL_W;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_OFF      = '1;
endpackage

// File: rtl/irq_level_regs.sv
module irq_level_regs
    import irq_level_pkg::*;
#(
    parameter int N_SRC  = 12,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h7C
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    output lvl_t [N_SRC-1:0]        levels_o
);
    localparam int N_REG = (N_SRC + FIELDS_PER_REG - 1) / FIELDS_PER_REG;

    typedef struct packed {
        logic [N_REG-1:0][7:0] regs;
    } state_t;

    state_t state_d, state_q;
    logic   addr_hit;

    always_comb begin
        state_d  = state_q;
        addr_hit = 1'b0;
        for (int r = 0; r < N_REG; r++) begin
            if (bus_addr == BASE_ADDR + ADDR_W'(r)) begin
                addr_hit = 1'b1;
                if (bus_wr) state_d.regs[r] = bus_wdata;
            end
        end
        if (rst) state_d.regs = '1;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign bus_rdata = addr_hit ? 8'hFF : 8'h00;

    for (genvar n = 0; n < N_SRC; n++) begin : g_field
        assign levels_o[n] =
            state_q.regs[n / FIELDS_PER_REG][LVL_W*(n % FIELDS_PER_REG) +: LVL_W];
    end

    // R1
    reset_levels_chk: assert property (@(posedge clk)
        rst |=> (levels_o == '1));

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == BASE_ADDR) |=> (levels_o[0] == $past(bus_wdata[1:0])));

    // R9
    stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        !addr_hit |=> $stable(levels_o));
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
    import irq_level_pkg::*;
#(
    parameter int N_SRC = 12,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  lvl_t [N_SRC-1:0]     levels_i,
    input  logic [N_SRC-1:0]     irq_req,
    input  lvl_t                 cpu_level,
    output logic                 irq_take,
    output logic [IDX_W-1:0]     irq_idx,
    output lvl_t                 irq_lvl
);
    always_comb begin
        irq_take = 1'b0;
        irq_idx  = '0;
        irq_lvl  = LVL_OFF;
        for (int i = 0; i < N_SRC; i++) begin
            if (irq_req[i] && levels_i[i] != LVL_OFF && levels_i[i] < cpu_level
                && (!irq_take || levels_i[i] < irq_lvl)) begin
                irq_take = 1'b1;
                irq_idx  = IDX_W'(i);
                irq_lvl  = levels_i[i];
            end
        end
    end

    // R6
    below_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (irq_lvl < cpu_level));

    // R5
    never_off_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (irq_lvl != LVL_OFF));

    // R6
    winner_pending_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> irq_req[irq_idx]);

    // R10
    idle_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_take |-> (irq_idx == '0 && irq_lvl == LVL_OFF));
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_level_pkg::*;
#(
    parameter int N_SRC  = 12,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h7C,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [N_SRC-1:0]  irq_req,
    input  logic [1:0]        cpu_level,
    output logic              irq_take,
    output logic [IDX_W-1:0]  irq_idx,
    output logic [1:0]        irq_lvl
);
    lvl_t [N_SRC-1:0] levels;

    irq_level_regs #(
        .N_SRC(N_SRC), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
    ) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .levels_o(levels)
    );

    irq_level_arbiter #(.N_SRC(N_SRC)) u_arb (
        .clk(clk), .rst(rst), .levels_i(levels), .irq_req(irq_req),
        .cpu_level(cpu_level), .irq_take(irq_take), .irq_idx(irq_idx),
        .irq_lvl(irq_lvl)
    );
endmodule

// File: tb/tb_irq_level_ctrl.sv
module tb_irq_level_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [11:0] irq_req = '0;
    logic [1:0]  cpu_level = 2'd3;
    logic        irq_take;
    logic [3:0]  irq_idx;
    logic [1:0]  irq_lvl;

    int checks = 0;
    int fails  = 0;
    logic [1:0] model_lv [12];

    typedef struct { logic take; logic [3:0] idx; logic [1:0] lvl; string tag; } exp_t;
    exp_t sb_q[$];
    event chk_ev;

    always #4 clk = ~clk;

    irq_level_ctrl dut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: apply request set and CPU level, push expected result
    task automatic drive(logic [11:0] req, logic [1:0] cpu, string tag);
        exp_t e;
        @(negedge clk);
        irq_req = req;
        cpu_level = cpu;
        e.take = 1'b0; e.idx = 4'd0; e.lvl = 2'd3; e.tag = tag;
        for (int i = 0; i < 12; i++)
            if (req[i] && model_lv[i] != 2'd3 && model_lv[i] < cpu
                && (!e.take || model_lv[i] < e.lvl)) begin
                e.take = 1'b1; e.idx = 4'(i); e.lvl = model_lv[i];
            end
        sb_q.push_back(e);
        #1 -> chk_ev;
        #1;
    endtask

    task automatic write_reg(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        if (a >= 8'h7C && a <= 8'h7E)
            for (int k = 0; k < 4; k++) model_lv[(a - 8'h7C) * 4 + k] = d[2*k +: 2];
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // monitor: pop and compare
    initial forever begin
        exp_t e;
        @(chk_ev);
        e = sb_q.pop_front();
        check({e.tag, " take"}, 32'(irq_take), 32'(e.take));
        check({e.tag, " idx"},  32'(irq_idx),  32'(e.idx));
        check({e.tag, " lvl"},  32'(irq_lvl),  32'(e.lvl));
    end

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 12; i++) model_lv[i] = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        drive(12'hFFF, 2'd3, "R1 reset all off");
        @(negedge clk) bus_addr = 8'h7C;
        #1 check("R4 read 7C", 32'(bus_rdata), 32'hFF);
        @(negedge clk) bus_addr = 8'h7D;
        #1 check("R4 read 7D", 32'(bus_rdata), 32'hFF);
        @(negedge clk) bus_addr = 8'h40;
        #1 check("R4 read other", 32'(bus_rdata), 32'h00);

        // R3: write sources 0..3 = 0,1,2,3; observe before and after edge
        @(negedge clk);
        irq_req = 12'h001; cpu_level = 2'd3;
        bus_addr = 8'h7C; bus_wdata = 8'b11_10_01_00; bus_wr = 1'b1;
        #1 check("R3 before edge take", 32'(irq_take), 32'd0);
        @(posedge clk);
        for (int k = 0; k < 4; k++) model_lv[k] = 2'(k);
        #1 check("R3 after edge take", 32'(irq_take), 32'd1);
        @(negedge clk) bus_wr = 1'b0;

        drive(12'h001, 2'd3, "R2 src0 lvl0");
        drive(12'h002, 2'd3, "R2 src1 lvl1");
        drive(12'h004, 2'd3, "R2 src2 lvl2");
        drive(12'h008, 2'd3, "R5 src3 lvl3");
        drive(12'h002, 2'd1, "R6 equal level pending");
        drive(12'h003, 2'd1, "R6 below cpu");
        drive(12'h001, 2'd0, "R6 cpu0 blocks all");
        drive(12'h006, 2'd2, "R6 mixed vs cpu2");

        write_reg(8'h7D, 8'h00);
        drive(12'h030, 2'd3, "R8 tie lowest index");
        drive(12'h042, 2'd3, "R7 smaller level beats index");
        drive(12'h0F0, 2'd1, "R8 tie four sources");

        write_reg(8'h7E, 8'h1B);
        drive(12'hF00, 2'd3, "R2 top field src11");
        drive(12'h100, 2'd3, "R5 src8 off");
        drive(12'h600, 2'd3, "R7 src10 over src9");
        drive(12'h600, 2'd2, "R6 src9 equal blocked");

        write_reg(8'h7F, 8'h00);
        write_reg(8'h7B, 8'h00);
        drive(12'h100, 2'd3, "R9 write 7F ignored");
        drive(12'h008, 2'd3, "R9 write 7B ignored");

        write_reg(8'h7C, 8'hFF);
        drive(12'h00F, 2'd3, "R5 all low sources off");
        drive(12'hFFF, 2'd3, "R7 full set");

        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        for (int i = 0; i < 12; i++) model_lv[i] = 2'd3;
        drive(12'hFFF, 2'd3, "R1 re-reset all off");
        drive(12'h000, 2'd3, "R10 no request");

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule